// File: doc/BRIEF.md
# Programmable Chip-Select Decoder with Boot Alias

This block decodes a 32-bit processor address into one of eight active-low chip-selects. Each bank owns a base register and a mask register, both loaded over a small write-only register bus. A bank answers when the masked bus address equals its masked base and the bank is marked valid. When no bank answers, the block raises a bus-error output and drives no chip-select. When several banks answer, the lowest-numbered one wins and a sticky overlap flag is set.

Bank 0 is the boot bank and is wired to the boot flash. Out of reset it answers for every address, so a 128 KB flash appears in every 128 KB block of the 4 GB space. The processor's first fetch, at offset 0x100 of either possible vector base, therefore lands in flash. Boot software then gives bank 0 a fixed window, for example 0xFE000000, by writing its base register with the valid bit set. From that write until the next reset, bank 0 decodes only its own window. Banks 1 to 7 stay invalid until software programs them.

Top module: `csdec_top`

## Requirements
- R1: After reset, every chip-select is high, the bus-error output is low, the overlap flag is 0, and boot-alias mode is active.
- R2: In boot-alias mode, any bus cycle asserts chip-select 0, whatever the address (for example 0x00000100, 0xFFF00100 and 0x7A5C0004).
- R3: The address and the cycle-valid input are registered on a clock edge. Chip-selects and bus error follow from the registered values in the cycle after that edge. With no cycle registered, all chip-selects are high and bus error is low.
- R4: Register bus byte offsets: bank k's base register is at 8·k and its mask register at 8·k+4. Base bits 31:15 hold the window base and bit 0 is the valid bit. Mask bits 31:15 hold the compare mask, and mask bits 14:0 are ignored. A write takes effect at the next clock edge.
- R5: A valid bank matches when the address bits 31:15, ANDed with its mask, equal its base bits 31:15 ANDed with the same mask. The decode granularity is therefore 32 KB.
- R6: Boot-alias mode ends only on a write to bank 0's base register with bit 0 set. A mask write or a base write with bit 0 clear leaves it active. Once ended, it stays ended until reset, and bank 0 then answers only inside its programmed window.
- R7: Banks 1 to 7 are invalid after reset and select nothing until software writes their base register with bit 0 set.
- R8: When several banks match, only the lowest-numbered matching bank's chip-select goes low.
- R9: A cycle that matches two or more banks sets the overlap flag one clock after the cycle's chip-select appears. The flag stays set until a write to offset 0x40 with bit 0 set clears it. A write there with bit 0 clear has no effect.
- R10: A registered cycle that matches no bank raises bus error and leaves all chip-selects high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 7 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| bus_valid_i | input | 1 | Processor bus cycle valid |
| bus_addr_i | input | 32 | Processor bus address |
| cs_n_o | output | 8 | Active-low chip-selects, one per bank |
| bus_err_o | output | 1 | No bank matched the registered cycle |
| ovl_err_o | output | 1 | Sticky overlap flag |

## Verification
Some behaviours are checked by assertions on every cycle. Bus error and chip-selects never appear together. Nothing is selected when no cycle is registered. A raw bank 0 hit always wins the decode. A multi-bank hit always sets the overlap flag on the following edge. Once boot-alias mode has ended, it never returns, and a valid write to bank 0's base always ends it.

Other behaviours can only be shown by the bench's scenarios. These cover the address-independent alias before the remap, and the way mask writes and invalid base writes leave the alias untouched. They also cover the relocated flash window and its 128 KB boundary, priority between nested windows, the ignored low mask bits, the bank 7 register offsets, and the write-one-to-clear behaviour of the flag.

// File: rtl/csdec_pkg.sv
package csdec_pkg;
    localparam int ADDR_W    = 32;
    localparam int GRAN_LOG2 = 15;
    localparam int TAG_W     = ADDR_W - GRAN_LOG2;
    typedef logic [TAG_W-1:0] tag_t;
endpackage

// File: rtl/csdec_regs.sv
module csdec_regs
    import csdec_pkg::*;
#(
    parameter int NBANK = 8,
    localparam int RA_W = $clog2(NBANK * 8) + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_wr_i,
    input  logic [RA_W-1:0]         reg_addr_i,
    input  logic [ADDR_W-1:0]       reg_wdata_i,
    output tag_t [NBANK-1:0]        base_o,
    output tag_t [NBANK-1:0]        mask_o,
    output logic [NBANK-1:0]        vld_o,
    output logic                    boot_o,
    output logic                    clr_o
);
    localparam int BI_W = RA_W - 4;

    typedef struct packed {
        tag_t [NBANK-1:0] base;
        tag_t [NBANK-1:0] mask;
        logic [NBANK-1:0] vld;
        logic             boot;
    } regs_t;

    regs_t st_d, st_q;
    logic  unused_bits;
    logic  in_banks;
    logic [BI_W-1:0] bidx;

    assign unused_bits = ^reg_wdata_i[GRAN_LOG2-1:1];
    assign in_banks    = ~reg_addr_i[RA_W-1];
    assign bidx        = reg_addr_i[RA_W-2:3];

    always_comb begin
        st_d = st_q;
        if (reg_wr_i && in_banks && reg_addr_i[1:0] == 2'b00) begin
            for (int k = 0; k < NBANK; k++) begin
                if (bidx == BI_W'(k)) begin
                    if (reg_addr_i[2]) begin
                        st_d.mask[k] = reg_wdata_i[ADDR_W-1:GRAN_LOG2];
                    end else begin
                        st_d.base[k] = reg_wdata_i[ADDR_W-1:GRAN_LOG2];
                        st_d.vld[k]  = reg_wdata_i[0];
                        if (k == 0 && reg_wdata_i[0]) st_d.boot = 1'b0;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.boot <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign base_o = st_q.base;
    assign mask_o = st_q.mask;
    assign vld_o  = st_q.vld;
    assign boot_o = st_q.boot;
    assign clr_o  = reg_wr_i && reg_addr_i == RA_W'(NBANK * 8) && reg_wdata_i[0];

    // R6
    boot_stays_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !boot_o |=> !boot_o);

    // R6
    boot_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i == '0 && reg_wdata_i[0]) |=> !boot_o);
endmodule

// File: rtl/csdec_match.sv
module csdec_match
    import csdec_pkg::*;
(
    input  tag_t addr_i,
    input  tag_t base_i,
    input  tag_t mask_i,
    input  logic vld_i,
    input  logic force_i,
    output logic hit_o
);
    always_comb begin
        hit_o = force_i | (vld_i && (((addr_i ^ base_i) & mask_i) == '0));
    end
endmodule

// File: rtl/csdec_prio.sv
module csdec_prio #(
    parameter int NBANK = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_i,
    input  logic [NBANK-1:0] hit_i,
    input  logic             clr_i,
    output logic [NBANK-1:0] cs_n_o,
    output logic             err_o,
    output logic             ovl_o
);
    typedef struct packed {
        logic ovl;
    } flag_t;

    flag_t st_d, st_q;
    logic [NBANK-1:0] sel;
    logic             multi;

    always_comb begin
        sel = '0;
        for (int k = NBANK - 1; k >= 0; k--) begin
            if (hit_i[k]) sel = NBANK'(1) << k;
        end
        multi = cyc_i && ($countones(hit_i) > 1);
        st_d  = st_q;
        if (clr_i) st_d.ovl = 1'b0;
        if (multi) st_d.ovl = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cs_n_o = cyc_i ? ~sel : '1;
    assign err_o  = cyc_i && (hit_i == '0);
    assign ovl_o  = st_q.ovl;

    // R9
    ovl_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_i && $countones(hit_i) > 1) |=> ovl_o);

    // R8
    bank0_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_i && hit_i[0]) |-> !cs_n_o[0]);
endmodule

// File: rtl/csdec_top.sv
module csdec_top
    import csdec_pkg::*;
#(
    parameter int NBANK = 8,
    localparam int RA_W = $clog2(NBANK * 8) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_i,
    input  logic [RA_W-1:0]   reg_addr_i,
    input  logic [ADDR_W-1:0] reg_wdata_i,
    input  logic              bus_valid_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    output logic [NBANK-1:0]  cs_n_o,
    output logic              bus_err_o,
    output logic              ovl_err_o
);
    typedef struct packed {
        tag_t addr;
        logic cyc;
    } bus_t;

    bus_t st_d, st_q;
    tag_t [NBANK-1:0] base, mask;
    logic [NBANK-1:0] vld, hit;
    logic             boot, clr;
    logic             unused_low;

    assign unused_low = ^bus_addr_i[GRAN_LOG2-1:0];

    always_comb begin
        st_d.addr = bus_addr_i[ADDR_W-1:GRAN_LOG2];
        st_d.cyc  = bus_valid_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    csdec_regs #(.NBANK(NBANK)) i_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
        .reg_wdata_i(reg_wdata_i), .base_o(base), .mask_o(mask), .vld_o(vld),
        .boot_o(boot), .clr_o(clr)
    );

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        if (g == 0) begin : g_boot
            csdec_match i_match (
                .addr_i(st_q.addr), .base_i(base[g]), .mask_i(mask[g]),
                .vld_i(vld[g]), .force_i(boot), .hit_o(hit[g])
            );
        end else begin : g_plain
            csdec_match i_match (
                .addr_i(st_q.addr), .base_i(base[g]), .mask_i(mask[g]),
                .vld_i(vld[g]), .force_i(1'b0), .hit_o(hit[g])
            );
        end
    end

    csdec_prio #(.NBANK(NBANK)) i_prio (
        .clk(clk), .rst_n(rst_n), .cyc_i(st_q.cyc), .hit_i(hit), .clr_i(clr),
        .cs_n_o(cs_n_o), .err_o(bus_err_o), .ovl_o(ovl_err_o)
    );

    // R10
    err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err_o |-> (cs_n_o == '1));

    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_valid_i) |-> (cs_n_o == '1 && !bus_err_o));

    // R2
    boot_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (boot && $past(bus_valid_i)) |-> !cs_n_o[0]);
endmodule

// File: tb/test_csdec_top.sv
module test_csdec_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_i = 1'b0;
    logic [6:0]  reg_addr_i = '0;
    logic [31:0] reg_wdata_i = '0;
    logic        bus_valid_i = 1'b0;
    logic [31:0] bus_addr_i = '0;
    logic [7:0]  cs_n_o;
    logic        bus_err_o, ovl_err_o;

    int checks = 0;
    int errors = 0;
    logic [7:0] got_cs;
    logic       got_err;

    always #10 clk = ~clk;

    csdec_top i_csdec_top (
        .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
        .reg_wdata_i(reg_wdata_i), .bus_valid_i(bus_valid_i), .bus_addr_i(bus_addr_i),
        .cs_n_o(cs_n_o), .bus_err_o(bus_err_o), .ovl_err_o(ovl_err_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] off, input logic [31:0] d);
        @(negedge clk);
        reg_wr_i = 1'b1; reg_addr_i = off; reg_wdata_i = d;
        @(negedge clk);
        reg_wr_i = 1'b0;
    endtask

    task automatic cyc(input logic [31:0] a);
        @(negedge clk);
        bus_valid_i = 1'b1; bus_addr_i = a;
        @(negedge clk);
        got_cs = cs_n_o; got_err = bus_err_o;
        bus_valid_i = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 cs", {24'd0, cs_n_o}, 32'hFF);
        chk("R1 err", {31'd0, bus_err_o}, 0);
        chk("R1 ovl", {31'd0, ovl_err_o}, 0);
    endtask

    task automatic t_alias;
        cyc(32'h0000_0100); chk("R2 low vector", {24'd0, got_cs}, 32'hFE);
        cyc(32'hFFF0_0100); chk("R2 high vector", {24'd0, got_cs}, 32'hFE);
        cyc(32'h7A5C_0004); chk("R2 arbitrary", {24'd0, got_cs}, 32'hFE);
        @(negedge clk);
        chk("R3 idle after cycle", {23'd0, bus_err_o, cs_n_o}, 32'h0FF);
    endtask

    task automatic t_boot_hold;
        wr(7'h04, 32'hFFFE_0000);
        wr(7'h00, 32'hFE00_0000);
        cyc(32'h0000_0100); chk("R6 alias held", {24'd0, got_cs}, 32'hFE);
        wr(7'h08, 32'h0000_0001);
        wr(7'h0C, 32'hFF00_0000);
        cyc(32'h0000_0100); chk("R8 boot bank wins", {24'd0, got_cs}, 32'hFE);
        @(negedge clk);
        chk("R9 overlap set", {31'd0, ovl_err_o}, 1);
        wr(7'h40, 32'h0000_0000);
        chk("R9 write zero keeps", {31'd0, ovl_err_o}, 1);
        wr(7'h40, 32'h0000_0001);
        chk("R9 cleared", {31'd0, ovl_err_o}, 0);
    endtask

    task automatic t_remap;
        wr(7'h00, 32'hFE00_0001);
        cyc(32'hFFF0_0100);
        chk("R6 old block gone", {23'd0, got_err, got_cs}, 32'h1FF);
        cyc(32'hFE00_0100); chk("R6 new window", {24'd0, got_cs}, 32'hFE);
        cyc(32'hFE02_0000); chk("R10 past flash end", {23'd0, got_err, got_cs}, 32'h1FF);
        cyc(32'h00FF_FFFC); chk("R5 bank1 ram", {24'd0, got_cs}, 32'hFD);
        cyc(32'h4000_0000); chk("R7 unprogrammed banks", {23'd0, got_err, got_cs}, 32'h1FF);
        @(negedge clk);
        chk("R9 no overlap after remap", {31'd0, ovl_err_o}, 0);
    endtask

    task automatic t_prio;
        wr(7'h18, 32'h1000_0001); wr(7'h1C, 32'hF000_0000);
        wr(7'h10, 32'h1000_0001); wr(7'h14, 32'hFFFF_8000);
        cyc(32'h1000_0010); chk("R8 lower bank wins", {24'd0, got_cs}, 32'hFB);
        cyc(32'h1000_8000); chk("R5 outer bank only", {24'd0, got_cs}, 32'hF7);
        @(negedge clk);
        chk("R9 sticky", {31'd0, ovl_err_o}, 1);
        wr(7'h40, 32'h1);
        chk("R9 clear again", {31'd0, ovl_err_o}, 0);
    endtask

    task automatic t_bank7;
        wr(7'h3C, 32'hFFFF_FFFF);
        cyc(32'h8000_7FFC); chk("R7 bank7 not yet valid", {23'd0, got_err, got_cs}, 32'h1FF);
        wr(7'h38, 32'h8000_0001);
        cyc(32'h8000_7FFC); chk("R4 bank7 offsets", {24'd0, got_cs}, 32'h7F);
        cyc(32'h8000_8000); chk("R5 32KB edge", {23'd0, got_err, got_cs}, 32'h1FF);
    endtask

    initial begin
        fork
            begin
                #5 rst_n = 1'b0;
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                t_reset;
                t_alias;
                t_boot_hold;
                t_remap;
                t_prio;
                t_bank7;
            end
            begin
                repeat (5000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule